// File: doc/BRIEF.md
# Descriptor-Ring Memory Copy Engine

This block copies data from one place in memory to another, word by word, under the control of two descriptor rings. The rings share one slot index. Each source-ring slot gives a source address and a byte count. The destination-ring slot with the same index gives the destination address. Software sets up both rings in memory, programs their base addresses through a small register port, and then moves the transmit software index forward to hand slots over. The engine works through every slot from its own hardware index up to that software index. For each slot it fetches the descriptors, copies the data over a single-word memory request/response port, and marks the destination descriptor as done.

A one-cycle completion pulse accompanies every write-back, for use by a separate interrupt block. Enable bits can pause the engine between slots. Reset bits return the hardware indices to zero. Busy flags show whether a slot is still in progress. The ring depth, the per-descriptor byte limit and the position of the done flag are parameters.

Top module: `hc_ring_copier`

## Requirements
- R1: After reset the hardware indices, base registers and control bits read zero, the engine is idle, and the receive software index (offset 0x108) reads DEPTH-1.
- R2: The register offsets are: 0x000 transmit base, 0x004 transmit count, 0x008 transmit software index, 0x00C transmit hardware index (read-only), 0x100/0x104/0x108/0x10C the same four for the receive ring, 0x204 control, 0x208 reset. Writable registers read back what was written, limited to their implemented bits.
- R3: While both enables are set and the transmit hardware index differs from the transmit software index, the engine processes the slot at the hardware index. After each slot, both hardware indices advance by one modulo DEPTH, so the index wraps from DEPTH-1 to 0.
- R4: The byte count sits in bits 29:16 of the second descriptor word (offset 4). Its low two bits are ignored and it is clamped to MAX_LEN. That many bytes are copied in 32-bit words from the source address to the destination address, and no word beyond them is written.
- R5: When control bit 6 is set, the engine finishes a slot by writing the second word of the matching destination descriptor. The written word holds the copied byte count in bits 29:16, the done flag (bit 31 when DONE_HI=1, bit 15 when DONE_HI=0) and the last-segment flag one bit below the done flag. All other bits are zero.
- R6: `done_pulse` is high for exactly one cycle per write-back, and never when write-back is disabled.
- R7: A slot whose count is zero makes no data reads or writes: only the three descriptor reads and the write-back.
- R8: Processing starts only when control bit 0 (transmit enable) and bit 2 (receive enable) are both set. Clearing either bit during a slot lets that slot finish before the engine goes idle.
- R9: Control bits 1 and 3 read as one while a slot is in progress and zero once the engine is idle. A memory request keeps its address and direction until it is acknowledged.
- R10: Writing reset-register bit 0 sets the transmit hardware index to zero, and writing bit 16 sets the receive hardware index to zero.
- R11: The descriptors of slot i are at base + 16*i. The first word (offset 0) is the address and the second word (offset 4) is the length/status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | AW | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge; read data valid in the same cycle |
| mem_rdata | input | 32 | Memory read data |
| done_pulse | output | 1 | One-cycle pulse per destination descriptor written back |

## Verification
The bench builds the engine with DEPTH=8, MAX_LEN=64 and DONE_HI=0. The small ring brings a full wrap of the index within a short run. The 64-byte limit makes the length clamp observable with a modest memory model. DONE_HI=0 places the done and last flags at bits 15 and 14, next to the length field, so that a misplaced flag or a stray length bit shows up in the write-back word. The memory model varies its acknowledge latency from zero to two wait cycles, so that request holding is exercised in every descriptor and data phase.

// File: rtl/hc_pkg.sv
package hc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SRCP,
      ST_LEN,
      ST_DSTP,
      ST_RDAT,
      ST_WDAT,
      ST_WB
   } mv_state_e;

   localparam logic [11:0] OFS_TX_BASE = 12'h000;
   localparam logic [11:0] OFS_TX_CNT  = 12'h004;
   localparam logic [11:0] OFS_TX_SW   = 12'h008;
   localparam logic [11:0] OFS_TX_HW   = 12'h00C;
   localparam logic [11:0] OFS_RX_BASE = 12'h100;
   localparam logic [11:0] OFS_RX_CNT  = 12'h104;
   localparam logic [11:0] OFS_RX_SW   = 12'h108;
   localparam logic [11:0] OFS_RX_HW   = 12'h10C;
   localparam logic [11:0] OFS_CTRL    = 12'h204;
   localparam logic [11:0] OFS_RST     = 12'h208;

   localparam logic [31:0] CTRL_WMASK  = 32'h0000_0475;
   localparam logic [31:0] RST_WMASK   = 32'h0001_0001;
endpackage

// File: rtl/hc_regfile.sv
module hc_regfile
   import hc_pkg::*;
#(
   parameter int AW    = 32,
   parameter int DEPTH = 64,
   parameter int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [11:0]      addr,
   input  logic [31:0]      wdata,
   output logic [31:0]      rdata,
   input  logic             busy,
   input  logic             adv,
   output logic [AW-1:0]    tx_base,
   output logic [AW-1:0]    rx_base,
   output logic [IDX_W-1:0] tx_hw,
   output logic [IDX_W-1:0] tx_sw,
   output logic             en_tx,
   output logic             en_rx,
   output logic             wb_en
);
   localparam logic [IDX_W-1:0] RX_SW_INIT = IDX_W'(DEPTH - 1);

   logic [31:0]      tx_cnt_q, rx_cnt_q, ctrl_q, rst_q;
   logic [IDX_W-1:0] rx_sw_q, rx_hw_q;
   logic             wr_rst_tx, wr_rst_rx;

   assign wr_rst_tx = wr && (addr == OFS_RST) && wdata[0];
   assign wr_rst_rx = wr && (addr == OFS_RST) && wdata[16];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_base  <= '0;
         rx_base  <= '0;
         tx_cnt_q <= '0;
         rx_cnt_q <= '0;
         tx_sw    <= '0;
         rx_sw_q  <= RX_SW_INIT;
         ctrl_q   <= '0;
         rst_q    <= '0;
      end else if (wr) begin
         case (addr)
            OFS_TX_BASE: tx_base  <= AW'(wdata);
            OFS_TX_CNT:  tx_cnt_q <= wdata;
            OFS_TX_SW:   tx_sw    <= wdata[IDX_W-1:0];
            OFS_RX_BASE: rx_base  <= AW'(wdata);
            OFS_RX_CNT:  rx_cnt_q <= wdata;
            OFS_RX_SW:   rx_sw_q  <= wdata[IDX_W-1:0];
            OFS_CTRL:    ctrl_q   <= wdata & CTRL_WMASK;
            OFS_RST:     rst_q    <= wdata & RST_WMASK;
            default: ;
         endcase
      end
   end

   // hardware indices: a reset pulse wins over an advance in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_hw   <= '0;
         rx_hw_q <= '0;
      end else begin
         if (wr_rst_tx)  tx_hw <= '0;
         else if (adv)   tx_hw <= tx_hw + 1'b1;
         if (wr_rst_rx)  rx_hw_q <= '0;
         else if (adv)   rx_hw_q <= rx_hw_q + 1'b1;
      end
   end

   assign en_tx = ctrl_q[0];
   assign en_rx = ctrl_q[2];
   assign wb_en = ctrl_q[6];

   always_comb begin
      case (addr)
         OFS_TX_BASE: rdata = 32'(tx_base);
         OFS_TX_CNT:  rdata = tx_cnt_q;
         OFS_TX_SW:   rdata = 32'(tx_sw);
         OFS_TX_HW:   rdata = 32'(tx_hw);
         OFS_RX_BASE: rdata = 32'(rx_base);
         OFS_RX_CNT:  rdata = rx_cnt_q;
         OFS_RX_SW:   rdata = 32'(rx_sw_q);
         OFS_RX_HW:   rdata = 32'(rx_hw_q);
         OFS_CTRL:    rdata = ctrl_q | {28'd0, busy, 1'b0, busy, 1'b0};
         OFS_RST:     rdata = rst_q;
         default:     rdata = '0;
      endcase
   end

   p_hw_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      adv && !wr_rst_tx |=> tx_hw == $past(tx_hw) + 1'b1);
   p_rx_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_rst_rx |=> rx_hw_q == '0);
   p_tx_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_rst_tx |=> tx_hw == '0);
endmodule

// File: rtl/hc_mover.sv
module hc_mover
   import hc_pkg::*;
#(
   parameter int          AW      = 32,
   parameter int          IDX_W   = 6,
   parameter int          LEN_W   = 14,
   parameter int          MAX_LEN = 16'h3F80,
   parameter bit          DONE_HI = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    tx_base,
   input  logic [AW-1:0]    rx_base,
   input  logic [IDX_W-1:0] tx_hw,
   input  logic [IDX_W-1:0] tx_sw,
   input  logic             en_tx,
   input  logic             en_rx,
   input  logic             wb_en,
   output logic             busy,
   output logic             adv,
   output logic             done_pulse,
   output logic             mem_req,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [31:0]      mem_wdata,
   input  logic             mem_ack,
   input  logic [31:0]      mem_rdata
);
   localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_LEN);
   localparam logic [LEN_W-1:0] WORD_B  = LEN_W'(4);

   initial begin
      assert (MAX_LEN % 4 == 0 && MAX_LEN < (1 << LEN_W))
         else $error("MAX_LEN must be word aligned and fit the length field");
   end

   mv_state_e        state, nstate;
   logic [IDX_W-1:0] slot_q;
   logic [AW-1:0]    src_q, dst_q, txd, rxd;
   logic [LEN_W-1:0] len_q, rem_q, raw_len, cap_len;
   logic [31:0]      data_q, flag_bits, wb_word;

   generate
      if (DONE_HI) begin : g_flag_hi
         assign flag_bits = 32'hC000_0000;
      end else begin : g_flag_lo
         assign flag_bits = 32'h0000_C000;
      end
   endgenerate

   assign txd     = tx_base + (AW'(slot_q) << 4);
   assign rxd     = rx_base + (AW'(slot_q) << 4);
   assign raw_len = mem_rdata[16 +: LEN_W];
   assign cap_len = ((raw_len > LEN_CAP) ? LEN_CAP : raw_len) & ~LEN_W'(3);
   assign wb_word = (32'(len_q) << 16) | flag_bits;
   assign busy    = (state != ST_IDLE);

   always_comb begin
      nstate     = state;
      mem_req    = 1'b0;
      mem_we     = 1'b0;
      mem_addr   = '0;
      mem_wdata  = '0;
      adv        = 1'b0;
      done_pulse = 1'b0;
      case (state)
         ST_IDLE: if (en_tx && en_rx && (tx_hw != tx_sw)) nstate = ST_SRCP;
         ST_SRCP: begin
            mem_req  = 1'b1;
            mem_addr = txd;
            if (mem_ack) nstate = ST_LEN;
         end
         ST_LEN: begin
            mem_req  = 1'b1;
            mem_addr = txd + AW'(4);
            if (mem_ack) nstate = ST_DSTP;
         end
         ST_DSTP: begin
            mem_req  = 1'b1;
            mem_addr = rxd;
            if (mem_ack) nstate = (rem_q == '0) ? ST_WB : ST_RDAT;
         end
         ST_RDAT: begin
            mem_req  = 1'b1;
            mem_addr = src_q;
            if (mem_ack) nstate = ST_WDAT;
         end
         ST_WDAT: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = dst_q;
            mem_wdata = data_q;
            if (mem_ack) nstate = (rem_q == WORD_B) ? ST_WB : ST_RDAT;
         end
         ST_WB: begin
            if (wb_en) begin
               mem_req    = 1'b1;
               mem_we     = 1'b1;
               mem_addr   = rxd + AW'(4);
               mem_wdata  = wb_word;
               adv        = mem_ack;
               done_pulse = mem_ack;
               if (mem_ack) nstate = ST_IDLE;
            end else begin
               adv    = 1'b1;
               nstate = ST_IDLE;
            end
         end
         default: nstate = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         slot_q <= '0;
         src_q  <= '0;
         dst_q  <= '0;
         len_q  <= '0;
         rem_q  <= '0;
         data_q <= '0;
      end else begin
         state <= nstate;
         if (state == ST_IDLE) slot_q <= tx_hw;
         if (mem_ack) begin
            case (state)
               ST_SRCP: src_q <= mem_rdata[AW-1:0];
               ST_LEN: begin
                  len_q <= cap_len;
                  rem_q <= cap_len;
               end
               ST_DSTP: dst_q  <= mem_rdata[AW-1:0];
               ST_RDAT: data_q <= mem_rdata;
               ST_WDAT: begin
                  src_q <= src_q + AW'(4);
                  dst_q <= dst_q + AW'(4);
                  rem_q <= rem_q - WORD_B;
               end
               default: ;
            endcase
         end
      end
   end

   p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
   p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |=> !done_pulse);
   p_start_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_IDLE && !(en_tx && en_rx) |=> state == ST_IDLE);
   p_zero_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_DSTP && mem_ack && rem_q == '0 |=> state == ST_WB);
   p_pulse_needs_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |-> wb_en && mem_we);
endmodule

// File: rtl/hc_ring_copier.sv
module hc_ring_copier #(
   parameter int AW      = 32,
   parameter int DEPTH   = 64,
   parameter int MAX_LEN = 16'h3F80,
   parameter bit DONE_HI = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic [11:0]   reg_addr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [31:0]   mem_wdata,
   input  logic          mem_ack,
   input  logic [31:0]   mem_rdata,
   output logic          done_pulse
);
   localparam int IDX_W = $clog2(DEPTH);
   localparam int LEN_W = 14;

   initial begin
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("DEPTH must be a power of two");
      assert (AW >= 16 && AW <= 32) else $error("AW out of range");
   end

   logic [AW-1:0]    tx_base, rx_base;
   logic [IDX_W-1:0] tx_hw, tx_sw;
   logic             en_tx, en_rx, wb_en, busy, adv;

   hc_regfile #(.AW(AW), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .busy(busy), .adv(adv),
      .tx_base(tx_base), .rx_base(rx_base), .tx_hw(tx_hw), .tx_sw(tx_sw),
      .en_tx(en_tx), .en_rx(en_rx), .wb_en(wb_en)
   );

   hc_mover #(.AW(AW), .IDX_W(IDX_W), .LEN_W(LEN_W), .MAX_LEN(MAX_LEN),
              .DONE_HI(DONE_HI)) u_mover (
      .clk(clk), .rst_n(rst_n), .tx_base(tx_base), .rx_base(rx_base),
      .tx_hw(tx_hw), .tx_sw(tx_sw), .en_tx(en_tx), .en_rx(en_rx),
      .wb_en(wb_en), .busy(busy), .adv(adv), .done_pulse(done_pulse),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );
endmodule

// File: tb/sim_hc_ring_copier.sv
`timescale 1ns/1ps
module sim_hc_ring_copier;
   localparam int AW = 32, DEPTH = 8, MAXL = 64;
   localparam logic [31:0] TXB = 32'h200, RXB = 32'h300;
   localparam logic [31:0] FLAGS = 32'h0000_C000;

   logic clk = 0, rst_n = 0;
   logic reg_wr = 0;
   logic [11:0] reg_addr = 0;
   logic [31:0] reg_wdata = 0, reg_rdata;
   logic mem_req, mem_we, mem_ack, done_pulse;
   logic [AW-1:0] mem_addr;
   logic [31:0] mem_wdata, mem_rdata;

   always #10 clk = ~clk;

   hc_ring_copier #(.AW(AW), .DEPTH(DEPTH), .MAX_LEN(MAXL), .DONE_HI(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done_pulse(done_pulse)
   );

   // behavioural memory, acknowledge latency cycles through 0,1,2
   logic [31:0] mem [0:2047];
   int wcnt = 0, hs_cnt = 0, pulses = 0, checks = 0, fails = 0;
   assign mem_ack   = mem_req && (wcnt >= (hs_cnt % 3));
   assign mem_rdata = mem[mem_addr[12:2]];
   always @(posedge clk) begin
      if (mem_req && mem_ack) begin
         if (mem_we) mem[mem_addr[12:2]] <= mem_wdata;
         hs_cnt <= hs_cnt + 1;
         wcnt   <= 0;
      end else if (mem_req) wcnt <= wcnt + 1;
   end

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // per-clock monitor: pulse width and request holding
   logic prev_pulse = 0, prev_wait = 0;
   logic [AW-1:0] prev_addr = 0;
   logic prev_we = 0;
   always @(negedge clk) if (rst_n) begin
      if (done_pulse) pulses++;
      if (prev_pulse) chk("R6 pulse width", {31'd0, done_pulse}, 32'd0);
      if (prev_wait) begin
         chk("R9 request held", {31'd0, mem_req}, 32'd1);
         chk("R9 address stable", mem_addr, prev_addr);
         chk("R9 direction stable", {31'd0, mem_we}, {31'd0, prev_we});
      end
      prev_pulse = done_pulse;
      prev_wait  = mem_req && !mem_ack;
      prev_addr  = mem_addr;
      prev_we    = mem_we;
   end

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
      @(negedge clk); reg_wr = 0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] v);
      @(negedge clk); reg_addr = a; #1; v = reg_rdata;
   endtask

   task automatic put_slot(input int s, input logic [31:0] src, input logic [31:0] dst,
                           input logic [13:0] len, input int words);
      mem[(TXB + s*16) / 4]     = src;
      mem[(TXB + s*16) / 4 + 1] = {2'b00, len, 16'h0};
      mem[(RXB + s*16) / 4]     = dst;
      mem[(RXB + s*16) / 4 + 1] = 32'h0;
      for (int k = 0; k < words; k++) begin
         mem[src/4 + k] = 32'hA000_0000 + s*256 + k;
         mem[dst/4 + k] = 32'hDEAD_BEEF;
      end
   endtask

   task automatic wait_idle(input logic [31:0] hw);
      logic [31:0] v, c;
      for (int i = 0; i < 3000; i++) begin
         rd(12'h00C, v);
         rd(12'h204, c);
         if (v == hw && c[1] == 1'b0) break;
      end
   endtask

   task automatic chk_copy(input string tag, input logic [31:0] src, input logic [31:0] dst,
                           input int n, input int tail);
      for (int k = 0; k < n; k++) chk(tag, mem[dst/4 + k], mem[src/4 + k]);
      for (int k = n; k < n + tail; k++) chk(tag, mem[dst/4 + k], 32'hDEAD_BEEF);
   endtask

   function automatic logic [31:0] wbw(input int len);
      return (32'(len) << 16) | FLAGS;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int base_hs, base_p;
      for (int i = 0; i < 2048; i++) mem[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      rd(12'h00C, v); chk("R1 tx hw", v, 0);
      rd(12'h10C, v); chk("R1 rx hw", v, 0);
      rd(12'h108, v); chk("R1 rx sw", v, DEPTH-1);
      rd(12'h204, v); chk("R1 ctrl", v, 0);
      rd(12'h000, v); chk("R1 tx base", v, 0);
      // R2 programming and readback
      wr(12'h000, TXB); wr(12'h100, RXB);
      wr(12'h004, DEPTH); wr(12'h104, DEPTH);
      rd(12'h000, v); chk("R2 tx base", v, TXB);
      rd(12'h100, v); chk("R2 rx base", v, RXB);
      rd(12'h104, v); chk("R2 rx count", v, DEPTH);
      wr(12'h204, 32'hFFFF_FFFF);
      rd(12'h204, v); chk("R2 ctrl mask", v, 32'h475);
      wr(12'h204, 32'h45);
      // R3 R4 R5 R11 basic slot 0
      put_slot(0, 32'h400, 32'h1000, 14'd16, 6);
      base_p = pulses;
      wr(12'h008, 1); wait_idle(1);
      chk_copy("R4 copy slot0", 32'h400, 32'h1000, 4, 2);
      chk("R5 writeback slot0", mem[(RXB)/4 + 1], wbw(16));
      rd(12'h10C, v); chk("R3 rx hw after slot0", v, 1);
      chk("R6 one pulse", pulses - base_p, 1);
      // R7 zero length
      put_slot(1, 32'h500, 32'h1100, 14'd0, 2);
      base_hs = hs_cnt;
      wr(12'h008, 2); wait_idle(2);
      chk("R7 handshakes", hs_cnt - base_hs, 4);
      chk("R7 writeback", mem[(RXB + 16)/4 + 1], wbw(0));
      chk("R7 dst untouched", mem[32'h1100/4], 32'hDEAD_BEEF);
      // R4 clamp to MAX_LEN and alignment
      put_slot(2, 32'h600, 32'h1200, 14'd100, 20);
      put_slot(3, 32'h700, 32'h1300, 14'd18, 6);
      wr(12'h008, 4); wait_idle(4);
      chk_copy("R4 clamp", 32'h600, 32'h1200, 16, 2);
      chk("R4 clamp len field", mem[(RXB + 32)/4 + 1], wbw(64));
      chk_copy("R4 low bits ignored", 32'h700, 32'h1300, 4, 2);
      chk("R4 aligned len field", mem[(RXB + 48)/4 + 1], wbw(16));
      // R3 wrap: slots 4..7 then 0
      for (int s = 4; s < 8; s++) put_slot(s, 32'h800 + s*64, 32'h1400 + s*64, 14'd8, 3);
      put_slot(0, 32'hC00, 32'h1C00, 14'd12, 4);
      base_p = pulses;
      wr(12'h008, 1); wait_idle(1);
      rd(12'h00C, v); chk("R3 wrap tx hw", v, 1);
      rd(12'h10C, v); chk("R3 wrap rx hw", v, 1);
      chk("R6 five pulses", pulses - base_p, 5);
      chk_copy("R3 slot7 copy", 32'h800 + 7*64, 32'h1400 + 7*64, 2, 1);
      chk_copy("R11 slot0 reuse", 32'hC00, 32'h1C00, 3, 1);
      chk("R5 slot7 writeback", mem[(RXB + 112)/4 + 1], wbw(8));
      // R6 R5 write-back disabled
      wr(12'h204, 32'h05);
      put_slot(1, 32'h500, 32'h1100, 14'd8, 3);
      base_p = pulses;
      wr(12'h008, 2); wait_idle(2);
      chk("R6 no pulse without writeback", pulses - base_p, 0);
      chk("R5 no writeback", mem[(RXB + 16)/4 + 1], 0);
      chk_copy("R4 copy without writeback", 32'h500, 32'h1100, 2, 1);
      // R8 receive enable cleared blocks start
      wr(12'h204, 32'h41);
      put_slot(2, 32'h600, 32'h1200, 14'd4, 2);
      wr(12'h008, 3);
      repeat (30) @(negedge clk);
      rd(12'h00C, v); chk("R8 no start while disabled", v, 2);
      rd(12'h204, v); chk("R9 idle busy bits", v & 32'hA, 0);
      wr(12'h204, 32'h45); wait_idle(3);
      rd(12'h00C, v); chk("R8 resumes", v, 3);
      // R8 R9 clearing enable mid-slot
      put_slot(3, 32'h700, 32'h1300, 14'd64, 17);
      put_slot(4, 32'h900, 32'h1500, 14'd8, 3);
      wr(12'h008, 5);
      repeat (6) @(negedge clk);
      rd(12'h204, v); chk("R9 busy bits while active", v & 32'hA, 32'hA);
      wr(12'h204, 32'h40);
      wait_idle(4);
      repeat (20) @(negedge clk);
      rd(12'h00C, v); chk("R8 finishes in-flight slot only", v, 4);
      chk_copy("R8 in-flight slot copied", 32'h700, 32'h1300, 16, 1);
      chk("R8 next slot not copied", mem[32'h1500/4], 32'hDEAD_BEEF);
      // R10 index reset pulses
      wr(12'h208, 32'h0001_0001); wr(12'h208, 0);
      rd(12'h00C, v); chk("R10 tx hw cleared", v, 0);
      rd(12'h10C, v); chk("R10 rx hw cleared", v, 0);
      rd(12'h008, v); chk("R10 tx sw kept", v, 5);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule